// File: doc/BRIEF.md
# Shift-and-Add Decimating Low-Pass FIR

This block is a fixed-coefficient low-pass FIR filter that also lowers the sample rate by an integer factor. Each sample arrives with a one-cycle valid strobe. The block keeps a delay line of recent samples. Once every `DEC` accepted samples it forms one filtered, rounded and saturated result. Results for the discarded phases are never stored.

Every coefficient is a build-time constant written as at most three signed power-of-two digits. Each tap product is therefore a sum of up to three shifted copies of the sample, and the design contains no multiplier. The defaults describe a 16-tap (order 15) symmetric filter that decimates by 4. A 20-tap, decimate-by-2 variant is selected by setting `NTAPS=20, DEC=2`.

The default half-response, from the outer tap to the centre, is 1, 2, 4, 8, 12, 18, 24, 28. It is mirrored for the other half, which gives a DC gain of 194/128.

Top module: `fir_csd_decim`

## Requirements
- R1: While `rst` is high at a clock edge, the delay line is cleared, the phase count returns to zero, `out_valid` goes low and `out_data` goes to zero on that edge.
- R2: The phase count advances by one, modulo `DEC`, only on cycles with `in_valid` high. Cycles with `in_valid` low change neither the delay line nor the phase, whatever `in_data` holds.
- R3: `out_valid` is high for exactly one cycle: the cycle after the edge that accepts the input completing a group of `DEC` inputs. After reset, the number of outputs equals the number of accepted inputs divided by `DEC`, rounded down.
- R4: The output for accepted input n (0-based, with n+1 a multiple of `DEC`) is y = sum over k of h[k]·x[n−k]. Samples from before the last reset count as zero.
- R5: The coefficients are given as signed digits. Each digit is {sign[1:0], shift[2:0]}, with sign 00 = zero, 01 = +1 and 11 = −1. There are at most three digits per tap. For the default filter, an impulse of height A reproduces the values A·h[k] at the kept phases.
- R6: Before the shift, y is rounded by adding 2^(SCALE−1) and then shifting right arithmetically by `SCALE` (7 by default). Ties therefore round toward +∞: 64 gives 1, and −64 gives 0.
- R7: The scaled result is clamped to the signed range of `OUT_W` bits: [−2048, 2047] by default.
- R8: `out_data` holds its value in every cycle in which no new output is produced.
- R9: After a reset in mid-stream, the first output follows exactly `DEC` accepted inputs, and its value ignores all samples taken before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle strobe for a decimated result |
| out_data | output | OUT_W | Signed rounded and saturated result |

## Verification
One register lies between an input and the result it produces. The result for an input accepted at edge t is therefore visible from edge t+1 onward, and is flagged by `out_valid` in that single cycle only. The bench drives each input on a falling edge. On the next falling edge, after the capturing rising edge, it compares `out_valid` and `out_data` with a reference model that has been updated with that input. This compare is made on every cycle, both valid and idle. It therefore also confirms that idle cycles and the non-kept phases leave `out_data` unchanged.

// File: rtl/fir_csd_pkg.sv
package fir_csd_pkg;

    localparam int NDIG   = 3;
    localparam int COEF_W = 8;

    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_POS  = 2'b01,
        DIG_NEG  = 2'b11
    } dig_sign_e;

    typedef struct packed {
        dig_sign_e  sgn;
        logic [2:0] sh;
    } csd_digit_t;

    typedef csd_digit_t [NDIG-1:0] csd_coef_t;

    function automatic csd_digit_t mk_dig(dig_sign_e s, int sh);
        csd_digit_t d;
        d.sgn = s;
        d.sh  = 3'(sh);
        return d;
    endfunction

    // Symmetric default response; index folded about the centre.
    function automatic csd_coef_t tap_code(int k, int ntaps);
        csd_coef_t c;
        int m;
        for (int j = 0; j < NDIG; j++) c[j] = mk_dig(DIG_ZERO, 0);
        m = (k < ntaps / 2) ? k : (ntaps - 1 - k);
        case (m)
            0: c[0] = mk_dig(DIG_POS, 0);
            1: c[0] = mk_dig(DIG_POS, 1);
            2: c[0] = mk_dig(DIG_POS, 2);
            3: c[0] = mk_dig(DIG_POS, 3);
            4: begin c[0] = mk_dig(DIG_POS, 3); c[1] = mk_dig(DIG_POS, 2); end
            5: begin c[0] = mk_dig(DIG_POS, 4); c[1] = mk_dig(DIG_POS, 1); end
            6: begin c[0] = mk_dig(DIG_POS, 4); c[1] = mk_dig(DIG_POS, 3); end
            7: begin c[0] = mk_dig(DIG_POS, 5); c[1] = mk_dig(DIG_NEG, 2); end
            8: c[0] = mk_dig(DIG_POS, 5);
            9: begin c[0] = mk_dig(DIG_POS, 5); c[1] = mk_dig(DIG_POS, 2); end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dec_phase_ctr.sv
module dec_phase_ctr #(
    parameter int DEC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic last_o
);
    localparam int PW = (DEC > 1) ? $clog2(DEC) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(DEC - 1);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        last_o  = in_valid && (phase_q == PH_LAST);
        if (in_valid) begin
            phase_d = last_o ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_d;
    end

    p_phase_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(phase_q));

    p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !last_o) |=> (phase_q == $past(phase_q) + 1'b1));

    p_phase_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        last_o |=> (phase_q == '0));

endmodule

// File: rtl/csd_term_mult.sv
module csd_term_mult
    import fir_csd_pkg::*;
#(
    parameter int        IN_W  = 12,
    parameter int        ACC_W = 25,
    parameter csd_coef_t CODE  = '0
) (
    input  logic [IN_W-1:0]  x_i,
    output logic [ACC_W-1:0] p_o
);
    logic signed [ACC_W-1:0] xe;
    logic [NDIG-1:0][ACC_W-1:0] term;

    assign xe = {{(ACC_W - IN_W){x_i[IN_W-1]}}, x_i};

    for (genvar j = 0; j < NDIG; j++) begin : g_dig
        localparam dig_sign_e SG = CODE[j].sgn;
        localparam int        SH = int'(CODE[j].sh);
        if (SG == DIG_POS) begin : g_pos
            assign term[j] = xe <<< SH;
        end else if (SG == DIG_NEG) begin : g_neg
            assign term[j] = -(xe <<< SH);
        end else begin : g_zero
            assign term[j] = '0;
        end
    end

    always_comb begin
        p_o = '0;
        for (int j = 0; j < NDIG; j++) p_o = p_o + term[j];
    end

endmodule

// File: rtl/rnd_sat.sv
module rnd_sat #(
    parameter int ACC_W = 25,
    parameter int OUT_W = 12,
    parameter int SCALE = 7
) (
    input  logic [ACC_W-1:0] acc_i,
    output logic [OUT_W-1:0] y_o
);
    localparam logic signed [ACC_W:0] HALF = (ACC_W + 1)'(1) <<< (SCALE - 1);
    localparam logic signed [ACC_W:0] OMAX = {{(ACC_W - OUT_W + 2){1'b0}}, {(OUT_W - 1){1'b1}}};
    localparam logic signed [ACC_W:0] OMIN = ~OMAX;

    logic signed [ACC_W:0] ext, rnd, shr;

    always_comb begin
        ext = {acc_i[ACC_W-1], acc_i};
        rnd = ext + HALF;
        shr = rnd >>> SCALE;
        if (shr > OMAX)      y_o = OMAX[OUT_W-1:0];
        else if (shr < OMIN) y_o = OMIN[OUT_W-1:0];
        else                 y_o = shr[OUT_W-1:0];
    end

endmodule

// File: rtl/fir_csd_decim.sv
module fir_csd_decim
    import fir_csd_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int OUT_W = 12,
    parameter int DEC   = 4,
    parameter int NTAPS = 16,
    parameter int SCALE = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    localparam int ACC_W = IN_W + COEF_W + $clog2(NTAPS) + 1;

    typedef struct packed {
        logic [NTAPS-2:0][IN_W-1:0] dly;
        logic                       vld;
        logic [OUT_W-1:0]           dat;
    } state_t;

    state_t st_d, st_q;
    logic   last;
    logic [NTAPS-1:0][IN_W-1:0]  tap_x;
    logic [NTAPS-1:0][ACC_W-1:0] prod;
    logic [ACC_W-1:0]            acc;
    logic [OUT_W-1:0]            y_sat;

    dec_phase_ctr #(.DEC(DEC)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .last_o   (last)
    );

    // Tap 0 sees the arriving sample so the kept result includes it.
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        if (k == 0) begin : g_head
            assign tap_x[k] = in_data;
        end else begin : g_body
            assign tap_x[k] = st_q.dly[k-1];
        end
        csd_term_mult #(
            .IN_W  (IN_W),
            .ACC_W (ACC_W),
            .CODE  (tap_code(k, NTAPS))
        ) u_mul (
            .x_i (tap_x[k]),
            .p_o (prod[k])
        );
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAPS; k++) acc = acc + prod[k];
    end

    rnd_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SCALE(SCALE)) u_rs (
        .acc_i (acc),
        .y_o   (y_sat)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (in_valid) begin
            st_d.dly[0] = in_data;
            for (int i = 1; i < NTAPS - 1; i++) st_d.dly[i] = st_q.dly[i-1];
        end
        if (last) begin
            st_d.vld = 1'b1;
            st_d.dat = y_sat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    p_valid_after_last_r3: assert property (@(posedge clk) disable iff (rst)
        last |=> out_valid);

    p_valid_needs_last_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(last));

    p_hold_between_r8: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(out_data));

    if (DEC > 1) begin : g_single
        p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
            out_valid |=> !out_valid);
    end

endmodule

// File: tb/fir_csd_decim_tb_top.sv
module fir_csd_decim_tb_top;
    localparam int IN_W  = 12;
    localparam int OUT_W = 12;
    localparam int DEC   = 4;
    localparam int NTAPS = 16;
    localparam int OMAX  = 2047;
    localparam int OMIN  = -2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [IN_W-1:0] in_data = '0;
    logic out_valid;
    logic [OUT_W-1:0] out_data;

    int tests = 0;
    int fails = 0;
    int hcoef [NTAPS] = '{1, 2, 4, 8, 12, 18, 24, 28, 28, 24, 18, 12, 8, 4, 2, 1};
    int hist [$];
    int in_cnt = 0;
    int out_cnt = 0;
    bit exp_vld = 1'b0;
    int exp_dat = 0;
    string tag = "R1";
    int lcg = 7;

    always #5 clk = ~clk;

    fir_csd_decim #(
        .IN_W(IN_W), .OUT_W(OUT_W), .DEC(DEC), .NTAPS(NTAPS), .SCALE(7)
    ) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int ref_out();
        int acc = 0;
        int r;
        for (int k = 0; k < NTAPS && k < hist.size(); k++) acc += hcoef[k] * hist[k];
        r = (acc + 64) >>> 7;
        if (r > OMAX) r = OMAX;
        if (r < OMIN) r = OMIN;
        return r;
    endfunction

    task automatic compare();
        int got;
        got = $signed(out_data);
        tests++;
        if (out_valid !== exp_vld || got != exp_dat) begin
            fails++;
            $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
                     tag, out_valid, got, exp_vld, exp_dat);
        end
        if (out_valid === 1'b1) out_cnt++;
    endtask

    task automatic step(bit v, int d);
        @(negedge clk);
        compare();
        rst      = 1'b0;
        in_valid = v;
        in_data  = IN_W'(d);
        exp_vld  = 1'b0;
        if (v) begin
            hist.push_front(d);
            in_cnt++;
            if (in_cnt % DEC == 0) begin
                exp_vld = 1'b1;
                exp_dat = ref_out();
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        compare();
        rst      = 1'b1;
        in_valid = 1'b0;
        hist.delete();
        in_cnt  = 0;
        out_cnt = 0;
        exp_vld = 1'b0;
        exp_dat = 0;
        @(negedge clk);
        tag = "R1";
        compare();
    endtask

    task automatic check_count();
        step(1'b0, 0);
        step(1'b0, 0);
        tests++;
        if (out_cnt != in_cnt / DEC) begin
            fails++;
            $display("FAIL R3: output count=%0d expected=%0d", out_cnt, in_cnt / DEC);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();

        tag = "R5";
        step(1'b1, 1024);
        for (int i = 0; i < 2 * NTAPS + 4; i++) step(1'b1, 0);
        check_count();

        tag = "R2";
        for (int i = 0; i < 24; i++) begin
            step(1'b1, 300 + 37 * i);
            step(1'b0, 1500 - i);
            if (i % 3 == 0) step(1'b0, -777);
        end
        check_count();

        tag = "R4";
        for (int i = 0; i < 200; i++) begin
            lcg = lcg * 1103515245 + 12345;
            step((i % 5) != 4, ((lcg >>> 8) & 4095) - 2048);
        end
        check_count();

        tag = "R7";
        for (int i = 0; i < 3 * NTAPS; i++) step(1'b1, 2047);
        for (int i = 0; i < 3 * NTAPS; i++) step(1'b1, -2048);
        check_count();

        do_reset();
        tag = "R6";
        step(1'b1, 0); step(1'b1, 0); step(1'b1, 0); step(1'b1, 64);
        step(1'b0, 0);
        do_reset();
        tag = "R6";
        step(1'b1, 0); step(1'b1, 0); step(1'b1, 0); step(1'b1, -64);
        step(1'b1, 0); step(1'b1, 0); step(1'b1, 0); step(1'b1, -65);
        step(1'b0, 0);

        tag = "R9";
        for (int i = 0; i < 10; i++) step(1'b1, 1800);
        do_reset();
        tag = "R9";
        for (int i = 0; i < 3 * DEC; i++) step(1'b1, 100 + i);
        check_count();

        tag = "R8";
        for (int i = 0; i < 6; i++) step(1'b0, 999);
        step(1'b0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule